// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block keeps the receive path supplied with buffer space. System memory holds a circular table of buffer descriptors. Each descriptor gives the start address of a free buffer and its size in words. When asked, the block reads the descriptor that its read pointer selects and loads the buffer address and the word count into its output registers. It then advances the read pointer around the table. It flags exhaustion when the read pointer meets the pointer that software uses to mark how far it has refilled the table.

A fetch can be started in three ways:
- a software command;
- software clearing the exhaustion flag;
- the receive path reporting a finished frame whose buffer has fewer words left than a programmable threshold.

Requests that arrive during a fetch are merged into one follow-on fetch. Memory reads go over a plain request/acknowledge port that carries one descriptor slot per beat. A slot is 16 bits wide in narrow mode. In wide mode it is 32 bits wide and only its low half is used.

Top module: `rx_ring_fetch`

## Requirements
- R1: A descriptor is four consecutive slots, read in this order: buffer address low, buffer address high, word count low, word count high. The block commits `buf_addr` = {slot1, slot0} and `buf_words` = {slot3, slot2}, taking the low 16 bits of each slot.
- R2: With `cfg_wide`=0 a slot is 2 bytes and the read pointer advances by 8. With `cfg_wide`=1 a slot is 4 bytes and the pointer advances by 16.
- R3: Beat k (k = 0 to 3) reads from address {`upper_addr`, `rd_ptr`} + k × slot size.
- R4: If the advanced pointer equals `ring_end`, `rd_ptr` is reloaded with `ring_start`.
- R5: The exhaustion check is made after the wrap step. If the final pointer equals `wr_ptr`, `exhausted` is set and `exh_irq` pulses for one cycle. A fetch that does not exhaust leaves `exh_irq` low.
- R6: `done` (the signal that clears the command bit) pulses for one cycle, on the cycle after the edge that accepts the last beat. If nothing is pending, `busy` is low in that same cycle.
- R7: A fetch starts on `cmd_fetch`, on `exh_clear`, or on `frame_done` when `frame_remain` < `eob_thresh`. `exh_clear` also clears `exhausted`. A `frame_done` with `frame_remain` >= `eob_thresh` starts nothing.
- R8: Once raised, `mem_req` stays high and `mem_addr` stays stable until `mem_ack` is seen.
- R9: Any number of triggers that arrive while busy cause exactly one extra fetch, which starts right after the current fetch ends.
- R10: `buf_addr`, `buf_words` and `rd_ptr` keep their old values until the last beat is accepted. A partly fetched descriptor is never visible.
- R11: `rp_load` writes `rp_load_val` into `rd_ptr` when the block is idle. While busy, `rp_load` is ignored.
- R12: After reset: `busy`, `mem_req`, `done`, `exh_irq` and `exhausted` are 0, and `rd_ptr`, `buf_addr` and `buf_words` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | Slot width select: 0 = 16-bit, 1 = 32-bit |
| upper_addr | input | 16 | Upper 16 address bits of the descriptor table |
| ring_start | input | 16 | First descriptor offset in the table |
| ring_end | input | 16 | Offset one past the last descriptor |
| wr_ptr | input | 16 | Refill pointer owned by software |
| rp_load | input | 1 | Load `rd_ptr` (takes effect only when idle) |
| rp_load_val | input | 16 | Value for `rp_load` |
| cmd_fetch | input | 1 | Fetch command pulse |
| exh_clear | input | 1 | Software clears the exhaustion flag (also starts a fetch) |
| frame_done | input | 1 | A received frame has completed |
| frame_remain | input | 32 | Words left in the current buffer after that frame |
| eob_thresh | input | 16 | Threshold below which a completed frame starts a fetch |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the requested slot |
| mem_ack | input | 1 | Memory read acknowledge; `mem_rdata` is valid with it |
| mem_rdata | input | 32 | Slot data (low 16 bits used) |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Remaining word count of the current buffer |
| rd_ptr | output | 16 | Descriptor read pointer |
| exhausted | output | 1 | Sticky flag: the descriptor table is exhausted |
| exh_irq | output | 1 | One-cycle pulse when `exhausted` is set |
| done | output | 1 | One-cycle pulse at the end of a fetch (clears the command bit) |
| busy | output | 1 | A fetch is in progress |

## Verification
The assertions assume that `cfg_wide`, `upper_addr`, `ring_start`, `ring_end` and `wr_ptr` do not change while `busy` is high. They also assume that memory raises `mem_ack` only while `mem_req` is high. The bench changes the configuration only between fetches, after `done`. Its memory model answers only when it sees a request, after a latency that varies from vector to vector. It computes each slot's data from the address it receives, so a slot read from the wrong address gives a wrong committed value.

// File: rtl/rx_ring_fetch.sv
module rx_ring_fetch #(
  parameter int FIELD_W = 16,
  parameter int SLOT_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wide,
  input  logic [FIELD_W-1:0]   upper_addr,
  input  logic [FIELD_W-1:0]   ring_start,
  input  logic [FIELD_W-1:0]   ring_end,
  input  logic [FIELD_W-1:0]   wr_ptr,
  input  logic                 rp_load,
  input  logic [FIELD_W-1:0]   rp_load_val,
  input  logic                 cmd_fetch,
  input  logic                 exh_clear,
  input  logic                 frame_done,
  input  logic [2*FIELD_W-1:0] frame_remain,
  input  logic [FIELD_W-1:0]   eob_thresh,
  output logic                 mem_req,
  output logic [2*FIELD_W-1:0] mem_addr,
  input  logic                 mem_ack,
  input  logic [SLOT_W-1:0]    mem_rdata,
  output logic [2*FIELD_W-1:0] buf_addr,
  output logic [2*FIELD_W-1:0] buf_words,
  output logic [FIELD_W-1:0]   rd_ptr,
  output logic                 exhausted,
  output logic                 exh_irq,
  output logic                 done,
  output logic                 busy
);
  localparam int AW = 2 * FIELD_W;

  logic [1:0]         beat;
  logic               pend;
  logic [FIELD_W-1:0] f0, f1, f2;
  logic [FIELD_W-1:0] d;
  logic [FIELD_W-1:0] stride, adv_ptr, new_ptr;
  logic [AW-1:0]      off;
  logic               trig, last, hit_wr;
  logic               unused_hi;

  assign d         = mem_rdata[FIELD_W-1:0];
  assign unused_hi = ^mem_rdata[SLOT_W-1:FIELD_W];
  assign trig      = cmd_fetch | exh_clear |
                     (frame_done && (frame_remain < {{FIELD_W{1'b0}}, eob_thresh}));
  assign stride    = cfg_wide ? FIELD_W'(16) : FIELD_W'(8);
  assign adv_ptr   = rd_ptr + stride;
  assign new_ptr   = (adv_ptr == ring_end) ? ring_start : adv_ptr;
  assign hit_wr    = (new_ptr == wr_ptr);
  assign off       = cfg_wide ? {{(AW-4){1'b0}}, beat, 2'b00} : {{(AW-3){1'b0}}, beat, 1'b0};
  assign mem_addr  = {upper_addr, rd_ptr} + off;
  assign mem_req   = busy;
  assign last      = busy && mem_ack && (beat == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      beat      <= 2'd0;
      pend      <= 1'b0;
      f0        <= '0;
      f1        <= '0;
      f2        <= '0;
      buf_addr  <= '0;
      buf_words <= '0;
      rd_ptr    <= '0;
      exhausted <= 1'b0;
      exh_irq   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done    <= last;
      exh_irq <= last && hit_wr;
      if (exh_clear) exhausted <= 1'b0;
      if (last && hit_wr) exhausted <= 1'b1;
      if (!busy) begin
        if (rp_load) rd_ptr <= rp_load_val;
        if (trig) begin
          busy <= 1'b1;
          beat <= 2'd0;
        end
      end else begin
        if (trig && !last) pend <= 1'b1;
        if (mem_ack) begin
          beat <= beat + 2'd1;
          case (beat)
            2'd0: f0 <= d;
            2'd1: f1 <= d;
            2'd2: f2 <= d;
            default: begin
              buf_addr  <= {f1, f0};
              buf_words <= {d, f2};
              rd_ptr    <= new_ptr;
              busy      <= pend | trig;
              pend      <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10
  no_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buf_addr) || !$stable(buf_words) |-> done);

  // R5
  exh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exhausted) |-> exh_irq);

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R11
  ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_ptr) |-> (done || $past(rp_load && !busy)));
endmodule

// File: tb/rx_ring_fetch_tb.sv
module rx_ring_fetch_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_wide, rp_load, cmd_fetch, exh_clear, frame_done;
  logic [15:0] upper_addr, ring_start, ring_end, wr_ptr, rp_load_val, eob_thresh;
  logic [31:0] frame_remain, mem_addr, mem_rdata, buf_addr, buf_words;
  logic mem_req, mem_ack, exhausted, exh_irq, done, busy;
  logic [15:0] rd_ptr;

  rx_ring_fetch dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .upper_addr(upper_addr),
    .ring_start(ring_start), .ring_end(ring_end), .wr_ptr(wr_ptr),
    .rp_load(rp_load), .rp_load_val(rp_load_val), .cmd_fetch(cmd_fetch),
    .exh_clear(exh_clear), .frame_done(frame_done), .frame_remain(frame_remain),
    .eob_thresh(eob_thresh), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .buf_addr(buf_addr),
    .buf_words(buf_words), .rd_ptr(rd_ptr), .exhausted(exhausted),
    .exh_irq(exh_irq), .done(done), .busy(busy)
  );

  int total = 0, fails = 0, cyc = 0, lat = 0, wait_cnt = 0, done_cnt = 0;

  function automatic logic [15:0] mv(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  always @(negedge clk) begin
    if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= {16'hBEEF, mv(mem_addr)};
        wait_cnt  <= 0;
      end else begin
        mem_ack  <= 1'b0;
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      mem_ack  <= 1'b0;
      wait_cnt <= 0;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      fails++;
      total++;
      $display("FAIL R6 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic wait_done();
    for (int n = 0; n < 200 && !done; n++) @(negedge clk);
  endtask

  task automatic pulse_fetch();
    cmd_fetch = 1'b1;
    @(negedge clk);
    cmd_fetch = 1'b0;
    wait_done();
  endtask

  task automatic setup(input logic w, input logic [15:0] rp, st, en, wr);
    cfg_wide = w; ring_start = st; ring_end = en; wr_ptr = wr;
    rp_load = 1'b1; rp_load_val = rp;
    @(negedge clk);
    rp_load = 1'b0;
  endtask

  // lat, wide, rp, start, end, wr, expected rp, expected exhausted
  localparam logic [83:0] VEC [6] = '{
    {2'd0, 1'b0, 16'h0100, 16'h0100, 16'h0140, 16'h0120, 16'h0108, 1'b0},
    {2'd1, 1'b0, 16'h0138, 16'h0100, 16'h0140, 16'h0120, 16'h0100, 1'b0},
    {2'd2, 1'b0, 16'h0110, 16'h0100, 16'h0140, 16'h0118, 16'h0118, 1'b1},
    {2'd0, 1'b1, 16'h0200, 16'h0200, 16'h0240, 16'h0230, 16'h0210, 1'b0},
    {2'd3, 1'b1, 16'h0230, 16'h0200, 16'h0240, 16'h0200, 16'h0200, 1'b1},
    {2'd1, 1'b0, 16'hFFF8, 16'h0000, 16'h0000, 16'h0040, 16'h0000, 1'b0}
  };

  initial begin
    logic [31:0] base, slot, old_addr;
    int start_cnt;
    rst_n = 1'b0; cfg_wide = 1'b0; rp_load = 1'b0; cmd_fetch = 1'b0;
    exh_clear = 1'b0; frame_done = 1'b0; frame_remain = '0; eob_thresh = 16'h00F8;
    upper_addr = 16'h0012; ring_start = '0; ring_end = '0; wr_ptr = 16'hFFFF;
    rp_load_val = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 busy", {31'b0, busy}, 32'd0);
    check("R12 mem_req", {31'b0, mem_req}, 32'd0);
    check("R12 done/irq/exh", {29'b0, done, exh_irq, exhausted}, 32'd0);
    check("R12 rd_ptr", {16'b0, rd_ptr}, 32'd0);
    check("R12 buf_addr", buf_addr, 32'd0);
    check("R12 buf_words", buf_words, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      if (exhausted) begin
        exh_clear = 1'b1;
        @(negedge clk);
        exh_clear = 1'b0;
        // R7 clearing the flag clears it and starts a fetch
        check("R7 exh_clear clears flag", {31'b0, exhausted}, 32'd0);
        check("R7 exh_clear starts fetch", {31'b0, busy}, 32'd1);
        wait_done();
        @(negedge clk);
      end
      lat = int'(VEC[i][83:82]);
      setup(VEC[i][81], VEC[i][80:65], VEC[i][64:49], VEC[i][48:33], VEC[i][32:17]);
      base = {upper_addr, VEC[i][80:65]};
      slot = VEC[i][81] ? 32'd4 : 32'd2;
      pulse_fetch();
      // R1 R2 R3 field order, slot size and beat addresses
      check("R1/R3 buf_addr", buf_addr, {mv(base + slot), mv(base)});
      check("R1/R2 buf_words", buf_words, {mv(base + 3*slot), mv(base + 2*slot)});
      // R2 R4 stride and wrap
      check("R4 rd_ptr", {16'b0, rd_ptr}, {16'b0, VEC[i][16:1]});
      // R5 exhaustion after wrap
      check("R5 exhausted", {31'b0, exhausted}, {31'b0, VEC[i][0]});
      check("R5 exh_irq", {31'b0, exh_irq}, {31'b0, VEC[i][0]});
      // R6 done pulse ends busy
      check("R6 done/busy", {30'b0, done, busy}, 32'd2);
      @(negedge clk);
      check("R6 done one cycle", {31'b0, done}, 32'd0);
    end

    // R7 frame trigger at threshold does nothing
    lat = 0;
    setup(1'b0, 16'h0100, 16'h0100, 16'h0140, 16'h0000);
    frame_remain = 32'h0000_00F8; frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    @(negedge clk);
    check("R7 frame at threshold ignored busy", {31'b0, busy}, 32'd0);
    check("R7 frame at threshold ignored ptr", {16'b0, rd_ptr}, 32'h0100);
    frame_remain = 32'h0000_00F7; frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    check("R7 frame below threshold starts", {31'b0, busy}, 32'd1);
    wait_done();
    check("R7 frame fetch ptr", {16'b0, rd_ptr}, 32'h0108);
    @(negedge clk);

    // R9 R10 R11 merged triggers, no partial commit, load ignored while busy
    lat = 2;
    old_addr = buf_addr;
    start_cnt = done_cnt;
    cmd_fetch = 1'b1;
    @(negedge clk);
    cmd_fetch = 1'b1; rp_load = 1'b1; rp_load_val = 16'h0130;
    @(negedge clk);
    cmd_fetch = 1'b0; rp_load = 1'b0; exh_clear = 1'b1;
    @(negedge clk);
    exh_clear = 1'b0;
    @(negedge clk);
    check("R10 buf_addr held mid-fetch", buf_addr, old_addr);
    check("R11 rd_ptr held mid-fetch", {16'b0, rd_ptr}, 32'h0108);
    wait_done();
    check("R10 first commit", {16'b0, rd_ptr}, 32'h0110);
    @(negedge clk);
    check("R9 follow-on fetch runs", {31'b0, busy}, 32'd1);
    wait_done();
    check("R9 second commit ptr", {16'b0, rd_ptr}, 32'h0118);
    repeat (30) @(negedge clk);
    check("R9 exactly one extra fetch", done_cnt - start_cnt, 32'd2);
    check("R9 idle after", {31'b0, busy}, 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule